// File: doc/BRIEF.md
# RTC register front end with key-protected calendar loading

This block is the register front end of a calendar real-time clock. It decodes a 32-bit single-cycle read/write bus at fixed byte offsets. It holds a small key state machine that guards every register able to disturb timekeeping. It runs the handshake that stops the calendar counter so that time, date and prescaler can be loaded safely. It also runs the resynchronisation flag that tells software when the readable calendar copies are current again.

Software unlocks the block with two key writes and requests init mode. It waits for the acknowledge flag, which appears only after the request has crossed a two-stage synchroniser clocked by RTC ticks. It then writes the time and date, which the block passes to the calendar counter as one-cycle load strobes with the unused bits cleared. Software then drops the request and clears the resync flag. Two RTC ticks later the flag comes back and the shadow copies hold the newly loaded calendar. Any other key value locks the block again.

Top module: `rtc_regif`

## Requirements
- R1: After reset the block is locked. The status word reads 0. The prescaler reads 0x007F00FF, with the fine divider in bits 14:0 and the coarse divider in bits 22:16. Control, time, date and key all read 0.
- R2: Writing 0xCA and then 0x53 in the low byte at the key offset 0x24 unlocks the protected registers.
- R3: While locked, writes to the prescaler at 0x10, to the control register at 0x18 and to the init request (status bit 7 at 0x0C) leave their read values unchanged.
- R4: A key write other than 0x53 right after 0xCA returns the key sequence to the locked start. Any key write while unlocked, for example 0xFF, locks the block again.
- R5: After the init request is set, the acknowledge (status bit 6) and the `cal_halt_o` output rise on the second RTC tick and not before.
- R6: Clearing the init request drops the acknowledge and `cal_halt_o` on the next clock edge.
- R7: A write to time at 0x00 or to date at 0x04, made while unlocked and acknowledged, gives a one-cycle load strobe on the next cycle. The time value is masked with 0x3F7F7F and the date value with 0xFFFF3F. Without the acknowledge, no strobe is given.
- R8: Writing the status word with bit 5 at 0 clears the resync flag (bit 5), whether the block is locked or not. The flag sets again on the second RTC tick outside init mode, and at that point the shadows copy the calendar.
- R9: The initialised flag (status bit 4) sets when a date load carries a non-zero year in bits 23:16. It stays set until reset.
- R10: Time and date reads return shadow copies. These are refreshed by `cal_upd_i` outside init mode and frozen while the acknowledge is high.
- R11: When written unlocked and in init mode, the prescaler reads back masked with 0x007F7FFF. When written unlocked, the 24-hour format bit (control bit 6) reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| rtc_tick_i | input | 1 | One-cycle pulse per RTC clock period |
| cal_time_i | input | 22 | Live calendar time from the counter |
| cal_date_i | input | 24 | Live calendar date from the counter |
| cal_upd_i | input | 1 | Calendar has advanced, refresh shadows |
| cal_halt_o | output | 1 | Stop the calendar counter |
| ld_time_o | output | 1 | Load strobe for time |
| ld_time_val_o | output | 22 | Masked time value to load |
| ld_date_o | output | 1 | Load strobe for date |
| ld_date_val_o | output | 24 | Masked date value to load |
| pred_s_o | output | 15 | Fine prescaler divider |
| pred_a_o | output | 7 | Coarse prescaler divider |
| fmt_o | output | 1 | Hour format select |

## Verification
The bench builds the block with its default parameters: two synchroniser stages and prescaler reset values of 255 and 127. Because there are only two stages, the one-tick-early point of both the acknowledge and the resync flag can be reached with single tick pulses. A small calendar model in the bench takes the load strobes and advances only while not halted. This brings the frozen shadows during init mode and the refresh after resync within reach at the read port.

// File: rtl/rtc_regif_pkg.sv
package rtc_regif_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned TIME_W   = 22;
  localparam int unsigned DATE_W   = 24;
  localparam int unsigned PRED_S_W = 15;
  localparam int unsigned PRED_A_W = 7;
  localparam int unsigned PRED_A_LSB = 16;
  localparam int unsigned KEY_W    = 8;
  localparam int unsigned YEAR_LSB = 16;

  localparam logic [ADDR_W-1:0] OFF_TIME  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DATE  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_PRESC = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_KEY   = 8'h24;

  localparam int unsigned ST_INIT  = 7;
  localparam int unsigned ST_ACK   = 6;
  localparam int unsigned ST_RSF   = 5;
  localparam int unsigned ST_INITS = 4;
  localparam int unsigned CT_FMT   = 6;

  localparam logic [TIME_W-1:0] TIME_MASK = 22'h3F7F7F;
  localparam logic [DATE_W-1:0] DATE_MASK = 24'hFFFF3F;

  localparam logic [KEY_W-1:0] KEY_FIRST  = 8'hCA;
  localparam logic [KEY_W-1:0] KEY_SECOND = 8'h53;

  typedef enum logic [1:0] {
    WP_LOCKED = 2'd0,
    WP_HALF   = 2'd1,
    WP_OPEN   = 2'd2
  } wp_state_e;
endpackage

// File: rtl/rtc_wp_lock.sv
module rtc_wp_lock
  import rtc_regif_pkg::*;
#(
  parameter logic [KEY_W-1:0] K1 = KEY_FIRST,
  parameter logic [KEY_W-1:0] K2 = KEY_SECOND
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_we_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             open_o
);
  wp_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_we_i) begin
      unique case (st_q)
        WP_LOCKED: st_d = (key_i == K1) ? WP_HALF : WP_LOCKED;
        WP_HALF:   st_d = (key_i == K2) ? WP_OPEN : WP_LOCKED;
        default:   st_d = WP_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= WP_LOCKED;
    else         st_q <= st_d;
  end

  assign open_o = (st_q == WP_OPEN);
endmodule

// File: rtl/rtc_init_sync.sv
module rtc_init_sync #(
  parameter int unsigned STAGES = 2,
  localparam int unsigned CNT_W = $clog2(STAGES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic init_req_i,
  input  logic rsf_clr_i,
  output logic ack_o,
  output logic rsf_o,
  output logic resync_o
);
  logic [STAGES-1:0] sync_q;
  logic              pend_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rsf_q;
  logic              done;

  // request walks through the stages on RTC ticks; cleared at once when dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sync_q <= '0;
    else if (!init_req_i) sync_q <= '0;
    else if (tick_i)      sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign ack_o = sync_q[STAGES-1] & init_req_i;

  assign done = pend_q && tick_i && !init_req_i && (cnt_q == CNT_W'(STAGES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      rsf_q  <= 1'b0;
    end else if (rsf_clr_i) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
      rsf_q  <= 1'b0;
    end else if (done) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      rsf_q  <= 1'b1;
    end else if (pend_q && tick_i && !init_req_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rsf_o    = rsf_q;
  assign resync_o = done;
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] cal_time_i,
  input  logic [DATE_W-1:0] cal_date_i,
  input  logic              cal_upd_i,
  input  logic              frozen_i,
  input  logic              resync_i,
  output logic [TIME_W-1:0] time_o,
  output logic [DATE_W-1:0] date_o
);
  logic refresh;
  assign refresh = (cal_upd_i && !frozen_i) || resync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_o <= '0;
      date_o <= '0;
    end else if (refresh) begin
      time_o <= cal_time_i;
      date_o <= cal_date_i;
    end
  end
endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
  import rtc_regif_pkg::*;
#(
  parameter int unsigned         SYNC_STAGES = 2,
  parameter logic [PRED_S_W-1:0] PRED_S_RST  = 15'd255,
  parameter logic [PRED_A_W-1:0] PRED_A_RST  = 7'd127
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                rtc_tick_i,
  input  logic [TIME_W-1:0]   cal_time_i,
  input  logic [DATE_W-1:0]   cal_date_i,
  input  logic                cal_upd_i,
  output logic                cal_halt_o,
  output logic                ld_time_o,
  output logic [TIME_W-1:0]   ld_time_val_o,
  output logic                ld_date_o,
  output logic [DATE_W-1:0]   ld_date_val_o,
  output logic [PRED_S_W-1:0] pred_s_o,
  output logic [PRED_A_W-1:0] pred_a_o,
  output logic                fmt_o
);
  logic wr, rd, wp_open, ack, rsf, resync;
  logic wr_key, wr_stat, wr_time, wr_date, wr_presc, wr_ctrl;
  logic init_req_q, inits_q;
  logic [TIME_W-1:0] shd_time, time_in;
  logic [DATE_W-1:0] shd_date, date_in;
  logic [DATA_W-1:0] rd_mux;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  assign wr_key   = wr && (addr_i == OFF_KEY);
  assign wr_stat  = wr && (addr_i == OFF_STAT);
  assign wr_time  = wr && (addr_i == OFF_TIME)  && wp_open && ack;
  assign wr_date  = wr && (addr_i == OFF_DATE)  && wp_open && ack;
  assign wr_presc = wr && (addr_i == OFF_PRESC) && wp_open && ack;
  assign wr_ctrl  = wr && (addr_i == OFF_CTRL)  && wp_open;

  assign time_in = wdata_i[TIME_W-1:0] & TIME_MASK;
  assign date_in = wdata_i[DATE_W-1:0] & DATE_MASK;

  rtc_wp_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_we_i (wr_key),
    .key_i    (wdata_i[KEY_W-1:0]),
    .open_o   (wp_open)
  );

  rtc_init_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (rtc_tick_i),
    .init_req_i (init_req_q),
    .rsf_clr_i  (wr_stat && !wdata_i[ST_RSF]),
    .ack_o      (ack),
    .rsf_o      (rsf),
    .resync_o   (resync)
  );

  rtc_shadow u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cal_time_i (cal_time_i),
    .cal_date_i (cal_date_i),
    .cal_upd_i  (cal_upd_i),
    .frozen_i   (ack),
    .resync_i   (resync),
    .time_o     (shd_time),
    .date_o     (shd_date)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_req_q    <= 1'b0;
      inits_q       <= 1'b0;
      ld_time_o     <= 1'b0;
      ld_date_o     <= 1'b0;
      ld_time_val_o <= '0;
      ld_date_val_o <= '0;
      pred_s_o      <= PRED_S_RST;
      pred_a_o      <= PRED_A_RST;
      fmt_o         <= 1'b0;
    end else begin
      ld_time_o <= wr_time;
      ld_date_o <= wr_date;
      if (wr_stat && wp_open) init_req_q <= wdata_i[ST_INIT];
      if (wr_time) ld_time_val_o <= time_in;
      if (wr_date) begin
        ld_date_val_o <= date_in;
        if (date_in[DATE_W-1:YEAR_LSB] != '0) inits_q <= 1'b1;
      end
      if (wr_presc) begin
        pred_s_o <= wdata_i[PRED_S_W-1:0];
        pred_a_o <= wdata_i[PRED_A_LSB +: PRED_A_W];
      end
      if (wr_ctrl) fmt_o <= wdata_i[CT_FMT];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      OFF_TIME:  rd_mux[TIME_W-1:0] = shd_time;
      OFF_DATE:  rd_mux[DATE_W-1:0] = shd_date;
      OFF_STAT: begin
        rd_mux[ST_INIT]  = init_req_q;
        rd_mux[ST_ACK]   = ack;
        rd_mux[ST_RSF]   = rsf;
        rd_mux[ST_INITS] = inits_q;
      end
      OFF_PRESC: begin
        rd_mux[PRED_S_W-1:0]          = pred_s_o;
        rd_mux[PRED_A_LSB +: PRED_A_W] = pred_a_o;
      end
      OFF_CTRL:  rd_mux[CT_FMT] = fmt_o;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end

  assign cal_halt_o = ack;
endmodule

// File: rtl/rtc_regif_chk.sv
module rtc_regif_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic init_req,
  input logic ack,
  input logic rsf,
  input logic inits,
  input logic wp_open,
  input logic ld_time,
  input logic ld_date
);
  p_init_needs_open_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_req) |-> $past(wp_open));
  p_ack_needs_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |-> init_req);
  p_ack_rise_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack) |-> $past(tick_i));
  p_ack_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(init_req) |-> !ack);
  p_load_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_time || ld_date) |-> ($past(ack) && $past(wp_open)));
  p_load_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_time, ld_date}));
  p_rsf_rise_on_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsf) |-> ($past(tick_i) && !$past(init_req)));
  p_inits_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inits |=> inits);
endmodule

bind rtc_regif rtc_regif_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (rtc_tick_i),
  .init_req (init_req_q),
  .ack      (ack),
  .rsf      (rsf),
  .inits    (inits_q),
  .wp_open  (wp_open),
  .ld_time  (ld_time_o),
  .ld_date  (ld_date_o)
);

// File: tb/tb_rtc_regif.sv
module tb_rtc_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        tick = 1'b0, upd = 1'b0, adv = 1'b0;
  logic [21:0] cal_time = '0, ld_tv;
  logic [23:0] cal_date = '0, ld_dv;
  logic        halt, ld_t, ld_d, fmt;
  logic [14:0] ps;
  logic [6:0]  pa;

  int vectors = 0, miscompares = 0;
  logic rd_seen = 1'b0;
  bit   done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  rtc_regif dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rtc_tick_i(tick),
    .cal_time_i(cal_time), .cal_date_i(cal_date), .cal_upd_i(upd),
    .cal_halt_o(halt), .ld_time_o(ld_t), .ld_time_val_o(ld_tv),
    .ld_date_o(ld_d), .ld_date_val_o(ld_dv), .pred_s_o(ps), .pred_a_o(pa),
    .fmt_o(fmt)
  );

  // calendar model
  always @(posedge clk) begin
    if (ld_t) cal_time <= ld_tv;
    else if (adv && !halt) cal_time <= cal_time + 22'd1;
    if (ld_d) cal_date <= ld_dv;
  end

  // monitor
  always @(posedge clk) rd_seen <= req && !we;
  always @(negedge clk) begin
    if (rd_seen) begin
      vectors++;
      if (sb_q.size() == 0) begin
        miscompares++;
        $display("FAIL scoreboard: unexpected read, actual %h expected none", rdata);
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        if (rdata !== it.exp) begin
          miscompares++;
          $display("FAIL %s: actual %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    sb_q.push_back('{exp: exp, tag: tag});
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic rtc_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic advance();
    @(negedge clk); adv = 1'b1;
    @(negedge clk); adv = 1'b0; upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h0C, 32'h0, "R1 status");
    rd(8'h10, 32'h007F00FF, "R1 prescaler");
    rd(8'h18, 32'h0, "R1 control");
    rd(8'h00, 32'h0, "R1 time");
    rd(8'h04, 32'h0, "R1 date");
    rd(8'h24, 32'h0, "R1 key");
    chk({31'd0, halt}, 32'd0, "R1 halt");
    // R3 locked writes ignored
    wr(8'h0C, 32'h80);
    rd(8'h0C, 32'h0, "R3 init locked");
    wr(8'h10, 32'h00120345);
    rd(8'h10, 32'h007F00FF, "R3 prescaler locked");
    wr(8'h18, 32'h40);
    rd(8'h18, 32'h0, "R3 control locked");
    // R4 wrong second key
    wr(8'h24, 32'hCA); wr(8'h24, 32'h11); wr(8'h24, 32'h53);
    wr(8'h0C, 32'h80);
    rd(8'h0C, 32'h0, "R4 wrong second key");
    // R2 unlock
    wr(8'h24, 32'hCA); wr(8'h24, 32'h53);
    wr(8'h18, 32'h40);
    rd(8'h18, 32'h40, "R2 R11 control");
    chk({31'd0, fmt}, 32'd1, "R11 fmt out");
    // R7 time write without ack ignored
    wr(8'h00, 32'h00123456);
    @(negedge clk);
    chk({10'd0, cal_time}, 32'h0, "R7 no load without ack");
    // R5 init handshake
    wr(8'h0C, 32'h80);
    rd(8'h0C, 32'h80, "R2 R5 init set");
    rtc_tick();
    chk({31'd0, halt}, 32'd0, "R5 halt after one tick");
    rtc_tick();
    chk({31'd0, halt}, 32'd1, "R5 halt after two ticks");
    rd(8'h0C, 32'hC0, "R5 ack");
    // R11 prescaler
    wr(8'h10, 32'hFFE3C003);
    rd(8'h10, 32'h00634003, "R11 prescaler masked");
    // R7 loads
    wr(8'h00, 32'hFFD2B4D6);
    @(negedge clk);
    chk({10'd0, cal_time}, 32'h00123456, "R7 time load masked");
    wr(8'h04, 32'hFF212AFF);
    @(negedge clk);
    chk({8'd0, cal_date}, 32'h00212A3F, "R7 date load masked");
    rd(8'h0C, 32'hD0, "R9 inits set");
    // R10 frozen during init
    advance();
    rd(8'h00, 32'h0, "R10 shadow frozen");
    // R6 release
    wr(8'h0C, 32'h00);
    chk({31'd0, halt}, 32'd0, "R6 halt drops");
    rd(8'h0C, 32'h10, "R6 R8 rsf cleared");
    rtc_tick();
    rd(8'h0C, 32'h10, "R8 rsf after one tick");
    rtc_tick();
    rd(8'h0C, 32'h30, "R8 rsf set");
    rd(8'h00, 32'h00123456, "R8 time resync");
    rd(8'h04, 32'h00212A3F, "R8 date resync");
    // R10 refresh
    advance();
    rd(8'h00, 32'h00123457, "R10 shadow refresh");
    // R4 relock
    wr(8'h24, 32'hFF);
    wr(8'h0C, 32'hA0);
    rd(8'h0C, 32'h30, "R4 relocked init ignored");
    // R8 clear while locked, R9 sticky
    wr(8'h0C, 32'h00);
    rd(8'h0C, 32'h10, "R8 R9 clear while locked");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule